// File: doc/BRIEF.md
# Frequency Band Classifier

This block sorts an incoming digitised square wave into three frequency classes by counting its rising edges over a fixed gate window measured in reference clock cycles (nominally 50 MHz). At the end of every gate window the edge count is captured and compared against two programmable cutoff counts. Three active-high outputs follow from that comparison, one per class, and each one closes an external analog switch for that class: low-pass, high-pass and band-pass.

A two-bit selection input picks which of the three outputs may be driven: only the low class, only the high class, only the band class, or all three at once, each judged on its own. A global enable forces all three off. The gate length and both cutoffs are plain inputs, so the effective corner frequencies are `cutoff / (gate_len * Tref)`.

Top module: `freq_band_classifier`

## Requirements
- R1: The input passes through a two-stage synchroniser into the reference domain, and only its rising edges are counted, at most one per reference cycle.
- R2: Every `gate_len` reference cycles (a value of 0 acts as 1) the count for that window is captured, and the running count restarts from zero for the next window; a periodic input whose period divides the window gives exactly `gate_len / period` counts.
- R3: The edge count saturates at its all-ones value (2^CNT_W - 1) instead of wrapping.
- R4: The low output asserts when the captured count is less than or equal to `cut_lo`.
- R5: The high output asserts when the captured count is greater than or equal to `cut_hi`.
- R6: The band output asserts only when the captured count is strictly greater than `cut_lo` and strictly less than `cut_hi`; with `cut_lo < cut_hi` at most one output is high.
- R7: `sel` encodes 0 = low only, 1 = high only, 2 = band only, 3 = all three; outputs not selected stay low.
- R8: With `enable` low all three outputs are low one reference cycle later; raising it restores the classification one cycle later.
- R9: After reset, all outputs stay low until the first gate window has completed.
- R10: When `cut_lo >= cut_hi` the band output never asserts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_in | input | 1 | Digitised square wave, asynchronous to clk |
| enable | input | 1 | High allows the outputs, low forces them off |
| sel | input | 2 | Class selection: 0 low, 1 high, 2 band, 3 all |
| gate_len | input | GATE_W | Gate window length in reference cycles |
| cut_lo | input | CNT_W | Lower cutoff count |
| cut_hi | input | CNT_W | Upper cutoff count |
| lp_on | output | 1 | Low-class switch control |
| hp_on | output | 1 | High-class switch control |
| bp_on | output | 1 | Band-class switch control |

## Verification
The assertions take for granted that the cutoffs, selection and enable are held steady across the cycle in which the output register samples them, since each property relates settings in one cycle to outputs in the next, and that the input never shows more than one rising edge per reference cycle after synchronisation. The stimulus only changes settings on the falling clock edge and generates square waves with a period of at least two reference cycles. Periods are chosen to divide the gate length exactly, so every window holds a known edge count regardless of phase, and the sweep waits three full gates after any period or gate change before judging outputs.

// File: rtl/fbc_pkg.sv
package fbc_pkg;

  typedef enum logic [1:0] {
    SEL_LOW  = 2'd0,
    SEL_HIGH = 2'd1,
    SEL_BAND = 2'd2,
    SEL_ALL  = 2'd3
  } sel_e;

  typedef struct packed {
    logic lp;
    logic hp;
    logic bp;
  } band_t;

  // Three-way judgement of a count against two cutoffs (R4, R5, R6).
  function automatic band_t grade(input logic [31:0] cnt,
                                  input logic [31:0] lo,
                                  input logic [31:0] hi);
    band_t b;
    b.lp = (cnt <= lo);
    b.hp = (cnt >= hi);
    b.bp = (cnt > lo) && (cnt < hi);
    return b;
  endfunction

  // Which classes the selection lets through (R7).
  function automatic band_t sel_mask(input sel_e s);
    band_t m;
    m.lp = (s == SEL_LOW)  || (s == SEL_ALL);
    m.hp = (s == SEL_HIGH) || (s == SEL_ALL);
    m.bp = (s == SEL_BAND) || (s == SEL_ALL);
    return m;
  endfunction

endpackage

// File: rtl/fbc_edge_sync.sv
module fbc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], async_in};
      last  <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~last;

  // R1: a rising edge is a single-cycle event
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/fbc_gate_timer.sv
module fbc_gate_timer #(
  parameter int GATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GATE_W-1:0] gate_len,
  output logic              gate_end
);
  logic [GATE_W-1:0] tick;

  // the +1 is done one bit wider so an all-ones length does not wrap
  assign gate_end = ({1'b0, tick} + 1'b1) >= {1'b0, gate_len};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tick <= '0;
    else if (gate_end) tick <= '0;
    else               tick <= tick + 1'b1;
  end

  // R2: between window ends the timer advances by exactly one
  a_r2_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_end |=> tick == $past(tick) + 1'b1);

endmodule

// File: rtl/fbc_edge_counter.sv
module fbc_edge_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             gate_end,
  output logic [CNT_W-1:0] held,
  output logic             held_valid
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] acc;
  logic [CNT_W-1:0] acc_next;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v,
                                               input logic inc);
    return (inc && v != TOP) ? v + 1'b1 : v;
  endfunction

  assign acc_next = sat_inc(acc, rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc        <= '0;
      held       <= '0;
      held_valid <= 1'b0;
    end else if (gate_end) begin
      held       <= acc_next;
      acc        <= '0;
      held_valid <= 1'b1;
    end else begin
      acc <= acc_next;
    end
  end

  // R3: once at the top the running count stays there until the window ends
  a_r3_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == TOP && !gate_end) |=> acc == TOP);

  // R2: the running count restarts at every window end
  a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
    gate_end |=> acc == '0);

  // R1: at most one edge is added per cycle
  a_r1_one_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_end |=> (acc - $past(acc)) <= 1);

endmodule

// File: rtl/freq_band_classifier.sv
module freq_band_classifier #(
  parameter int CNT_W  = 16,
  parameter int GATE_W = 24,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sig_in,
  input  logic              enable,
  input  logic [1:0]        sel,
  input  logic [GATE_W-1:0] gate_len,
  input  logic [CNT_W-1:0]  cut_lo,
  input  logic [CNT_W-1:0]  cut_hi,
  output logic              lp_on,
  output logic              hp_on,
  output logic              bp_on
);
  import fbc_pkg::*;

  logic             rise;
  logic             gate_end;
  logic [CNT_W-1:0] held;
  logic             held_valid;
  band_t            judged;
  band_t            allowed;
  band_t            out_q;

  fbc_edge_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(sig_in), .rise(rise));

  fbc_gate_timer #(.GATE_W(GATE_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .gate_len(gate_len), .gate_end(gate_end));

  fbc_edge_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .rise(rise), .gate_end(gate_end),
    .held(held), .held_valid(held_valid));

  assign judged  = grade(32'(held), 32'(cut_lo), 32'(cut_hi));
  assign allowed = sel_mask(sel_e'(sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     out_q <= '0;
    else if (held_valid && enable)  out_q <= judged & allowed;
    else                            out_q <= '0;
  end

  assign lp_on = out_q.lp;
  assign hp_on = out_q.hp;
  assign bp_on = out_q.bp;

  // R8: disabled means all switches open on the next cycle
  a_r8_disable: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> {lp_on, hp_on, bp_on} == 3'b000);

  // R9: nothing asserts before a window has been captured
  a_r9_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    !held_valid |=> {lp_on, hp_on, bp_on} == 3'b000);

  // R10: inverted or equal cutoffs leave the band empty
  a_r10_band_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (cut_lo >= cut_hi) |=> !bp_on);

  // R6: ordered cutoffs give mutually exclusive classes
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (cut_lo < cut_hi) |=> $onehot0({lp_on, hp_on, bp_on}));

  // R7: low-only selection keeps the other two open
  a_r7_low_only: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'd0) |=> (!hp_on && !bp_on));

endmodule

// File: tb/test_freq_band_classifier.sv
`timescale 1ns/1ps
module test_freq_band_classifier;
  localparam int CW = 5;
  localparam int GW = 8;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sig_in = 1'b0;
  logic          enable = 1'b0;
  logic [1:0]    sel = 2'd3;
  logic [GW-1:0] gate_len = 8'd64;
  logic [CW-1:0] cut_lo = '0;
  logic [CW-1:0] cut_hi = '0;
  logic          lp_on, hp_on, bp_on;

  int per = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  freq_band_classifier #(.CNT_W(CW), .GATE_W(GW), .SYNC_N(2)) i_freq_band_classifier (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .enable(enable), .sel(sel),
    .gate_len(gate_len), .cut_lo(cut_lo), .cut_hi(cut_hi),
    .lp_on(lp_on), .hp_on(hp_on), .bp_on(bp_on));

  // square wave source: per = 0 holds low, otherwise half-period per/2 cycles
  initial begin
    forever begin
      if (per < 2) begin
        @(negedge clk);
        sig_in = 1'b0;
      end else begin
        repeat (per / 2) @(negedge clk);
        sig_in = ~sig_in;
      end
    end
  end

  function automatic logic [2:0] expect_bits(int c, int lo, int hi, int s, bit en);
    logic l, h, b;
    if (!en) return 3'b000;
    l = (c <= lo) && (s == 0 || s == 3);
    h = (c >= hi) && (s == 1 || s == 3);
    b = (c > lo) && (c < hi) && (s == 2 || s == 3);
    return {l, h, b};
  endfunction

  task automatic chk(input string req, input logic [2:0] exp);
    n_chk++;
    if ({lp_on, hp_on, bp_on} !== exp) begin
      n_fail++;
      $display("FAIL %s act=%b exp=%b (per=%0d gate=%0d lo=%0d hi=%0d sel=%0d en=%0b)",
               req, {lp_on, hp_on, bp_on}, exp, per, gate_len, cut_lo, cut_hi, sel, enable);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    int los[5];
    int his[5];
    int pers[7];
    los = '{0, 1, 3, 8, 16};
    his = '{2, 4, 9, 16, 31};
    pers = '{0, 2, 4, 8, 16, 32, 64};

    // R9: reset state and hold-off before the first window
    per = 4; enable = 1'b1; sel = 2'd3; cut_lo = 5'd31; cut_hi = 5'd31;
    repeat (3) @(negedge clk);
    chk("R9 in reset", 3'b000);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R9 before first gate", 3'b000);
    repeat (100) @(negedge clk);
    chk("R9 after first gate (count 16)", expect_bits(16, 31, 31, 3, 1));

    // R8: enable takes effect in one cycle each way
    enable = 1'b0;
    @(negedge clk);
    chk("R8 disable", 3'b000);
    enable = 1'b1;
    @(negedge clk);
    chk("R8 re-enable", expect_bits(16, 31, 31, 3, 1));

    // sweep gate lengths, periods, cutoffs and selections (R1-R7, R10)
    for (int g = 0; g < 2; g++) begin
      gate_len = (g == 0) ? 8'd64 : 8'd32;
      for (int p = 0; p < 7; p++) begin
        int cnt;
        if (g == 1 && pers[p] == 64) continue;
        per = pers[p];
        cnt = (per == 0) ? 0 : int'(gate_len) / per;
        if (cnt > CMAX) cnt = CMAX;  // R3 saturation at 2^CW-1
        repeat (3 * int'(gate_len) + 10) @(negedge clk);
        for (int a = 0; a < 5; a++) begin
          for (int b = 0; b < 5; b++) begin
            for (int s = 0; s < 4; s++) begin
              cut_lo = CW'(los[a]);
              cut_hi = CW'(his[b]);
              sel = 2'(s);
              repeat (2) @(negedge clk);
              if (los[a] >= his[b])
                chk("R10 empty band / R4 R5 R7", expect_bits(cnt, los[a], his[b], s, 1));
              else if (per == 2 && g == 0)
                chk("R3 saturated count / R1 R2", expect_bits(cnt, los[a], his[b], s, 1));
              else
                chk("R1 R2 R4 R5 R6 R7 classify", expect_bits(cnt, los[a], his[b], s, 1));
            end
          end
        end
        // R8 within the sweep
        enable = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 forced off", 3'b000);
        enable = 1'b1;
      end
    end

    finish_run();
  end

endmodule